// File: doc/BRIEF.md
# LIN Master Frame Sequencer

This block runs the master side of a LIN bus on top of a byte-level UART transmitter and receiver. A single request starts a frame. The block then sends the header: a break of selectable length, the sync byte 0x55 and the identifier byte. After the header it either transmits the data bytes and a checksum, or it collects the data bytes and the checksum that a slave returns. The number of data bytes may be zero.

Data for a transmit frame enters through a one-byte holding register with a valid/ready push. Received data bytes appear in a read register that the user pops. Three sticky status flags record frame completion, a checksum mismatch and a read-register overflow. Each flag is cleared by writing 1 to its bit, and each has its own interrupt enable. Baud timing and bit-level serialisation belong to the attached UART, which accepts one byte (or a break) per handshake and reports the end of it with a one-cycle done pulse.

Top module: `lin_frame_master`

## Requirements
- R1: A frame goes out in the order break, sync byte 0x55, identifier byte, data bytes, checksum. Each item is offered once on `tx_valid`, and the next item is offered only after `tx_done` for the previous one.
- R2: The break is offered with `tx_break` high and `tx_data` ignored. `tx_brk_long` is 1 when the request selected a 13-bit break (`req_brk13`=1) and 0 for a 10-bit break.
- R3: With `req_autopar`=1 the identifier byte is `{P1,P0,id[5:0]}`, where P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5). With `req_autopar`=0 the byte `req_id` is sent unchanged.
- R4: The checksum is the bitwise inverse of the 8-bit sum of the data bytes with end-around carry. With `req_enh`=1 the sent identifier byte is included in the sum.
- R5: In a receive frame (`req_rx`=1), each data byte from the slave appears on `rd_data` with `rd_avail`=1 until it is popped. The final byte is compared with the computed checksum. When `req_ckchk`=1 and the two differ, status bit 1 is set. When `req_ckchk`=0, status bit 1 is never set.
- R6: Status bit 0 (frame done) is set when the checksum byte completes, either through `tx_done` or through receipt. In that same cycle `busy` falls.
- R7: Status bit 2 (overflow) is set when a received data byte arrives while `rd_avail` is 1 and no pop happens in that cycle. The new byte replaces the old one.
- R8: Writing `st_wr_en`=1 clears every status bit whose `st_wr_data` bit is 1. When a flag is set and cleared in the same cycle, the set wins.
- R9: `irq` is 1 exactly when some status bit and the matching `irq_en` bit are both 1.
- R10: A request that arrives while `busy`=1 is ignored. It neither alters the running frame nor starts another frame afterwards.
- R11: A byte on `rx_valid` is ignored outside the data and checksum phases of a receive frame.
- R12: A frame with length 0 goes straight from the identifier byte to the checksum. Requested lengths above MAX_LEN are limited to MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a frame (taken only when idle) |
| req_id | input | 8 | Identifier (bits 5:0), or the full byte when parity is off |
| req_len | input | LEN_W | Number of data bytes |
| req_rx | input | 1 | 1: slave supplies data and checksum |
| req_brk13 | input | 1 | 1: 13-bit break, 0: 10-bit break |
| req_autopar | input | 1 | Generate identifier parity bits |
| req_enh | input | 1 | Include the identifier byte in the checksum |
| req_ckchk | input | 1 | Check the received checksum |
| wr_valid | input | 1 | Transmit data byte push |
| wr_data | input | 8 | Transmit data byte |
| wr_ready | output | 1 | Holding register empty |
| rd_pop | input | 1 | Consume the received byte |
| rd_avail | output | 1 | Received byte waiting |
| rd_data | output | 8 | Received data byte |
| tx_ready | input | 1 | UART can take an item |
| tx_done | input | 1 | UART finished the current item |
| tx_valid | output | 1 | Item offered to the UART |
| tx_data | output | 8 | Byte offered to the UART |
| tx_break | output | 1 | Offered item is a break |
| tx_brk_long | output | 1 | Break is 13 bits long |
| rx_valid | input | 1 | UART received a byte |
| rx_data | input | 8 | Received byte |
| st_wr_en | input | 1 | Write-1-to-clear strobe |
| st_wr_data | input | 3 | Bits to clear |
| irq_en | input | 3 | Per-flag interrupt enables |
| status | output | 3 | Flags: 0 done, 1 checksum error, 2 overflow |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of collision are provoked on purpose. In the first, the checksum byte of a receive frame arrives in the same cycle as a write-1-to-clear of the frame-done bit. Both are driven on one falling edge, and the bench expects the flag to read 1 one cycle later. In the second, a second data byte is received while the previous byte is still unread and no pop is made in that cycle. The bench expects the overflow flag to be set and the newer byte to sit in the read register. A request raised during a running frame is judged by the identifier byte that goes out and by the absence of any later frame.

// File: rtl/lin_pkg.sv
package lin_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_SYNC,
    ST_PID,
    ST_DATA,
    ST_CSUM
  } lin_state_e;

  localparam logic [7:0] SYNC_BYTE  = 8'h55;
  localparam int         NUM_FLAGS  = 3;
  localparam int         FLAG_DONE  = 0;
  localparam int         FLAG_CKERR = 1;
  localparam int         FLAG_OVF   = 2;

  // identifier with the two parity bits on top
  function automatic logic [7:0] lin_protect(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  // 8-bit add, carry folded back into bit 0
  function automatic logic [7:0] lin_csum_add(input logic [7:0] acc, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, acc} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_csum.sv
module lin_csum
  import lin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic [7:0] init_val,
  input  logic       add,
  input  logic [7:0] add_byte,
  output logic [7:0] csum_out
);

  logic [7:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= 8'h00;
    else if (init) acc_q <= init_val;
    else if (add)  acc_q <= lin_csum_add(acc_q, add_byte);
  end

  assign csum_out = ~acc_q;

  a_r4_seed: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (csum_out == ~$past(init_val)));

endmodule

// File: rtl/lin_seq.sv
module lin_seq
  import lin_pkg::*;
#(
  parameter  int MAX_LEN = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_rx,
  input  logic             tx_ready,
  input  logic             tx_done,
  input  logic             hold_full,
  input  logic             rx_valid,
  output lin_state_e       state,
  output logic             busy,
  output logic             tx_valid,
  output logic             ev_start,
  output logic             ev_tx_data,
  output logic             ev_rx_data,
  output logic             ev_rx_csum,
  output logic             ev_frame_done,
  output logic             rx_phase
);

  lin_state_e       st_q, st_d;
  logic             issued_q, issued_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_lim;
  logic             rx_q;
  logic             tx_phase, tx_take, byte_end, last_data;

  assign len_lim = (req_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : req_len;

  always_comb begin
    case (st_q)
      ST_BRK, ST_SYNC, ST_PID: tx_phase = 1'b1;
      ST_DATA, ST_CSUM:        tx_phase = !rx_q;
      default:                 tx_phase = 1'b0;
    endcase
  end

  assign rx_phase      = rx_q && (st_q == ST_DATA || st_q == ST_CSUM);
  assign tx_valid      = tx_phase && !issued_q && (st_q != ST_DATA || hold_full);
  assign tx_take       = tx_valid && tx_ready;
  assign ev_start      = (st_q == ST_IDLE) && req_valid;
  assign ev_tx_data    = tx_take && (st_q == ST_DATA);
  assign ev_rx_data    = rx_phase && (st_q == ST_DATA) && rx_valid;
  assign ev_rx_csum    = rx_phase && (st_q == ST_CSUM) && rx_valid;
  assign byte_end      = (tx_phase && issued_q && tx_done) || ev_rx_data || ev_rx_csum;
  assign last_data     = (cnt_q == len_q - LEN_W'(1));
  assign ev_frame_done = (st_q == ST_CSUM) && byte_end;
  assign busy          = (st_q != ST_IDLE);
  assign state         = st_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    issued_d = issued_q;
    if (tx_take)  issued_d = 1'b1;
    if (byte_end) issued_d = 1'b0;
    case (st_q)
      ST_IDLE: if (ev_start) begin st_d = ST_BRK; cnt_d = '0; end
      ST_BRK:  if (byte_end) st_d = ST_SYNC;
      ST_SYNC: if (byte_end) st_d = ST_PID;
      ST_PID:  if (byte_end) st_d = (len_q == '0) ? ST_CSUM : ST_DATA;
      ST_DATA: if (byte_end) begin
        if (last_data) begin st_d = ST_CSUM; cnt_d = '0; end
        else           cnt_d = cnt_q + LEN_W'(1);
      end
      ST_CSUM: if (byte_end) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      rx_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      cnt_q    <= cnt_d;
      if (ev_start) begin
        len_q <= len_lim;
        rx_q  <= req_rx;
      end
    end
  end

  a_r1_brk_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BRK && byte_end) |=> (st_q == ST_SYNC));
  a_r1_sync_then_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && byte_end) |=> (st_q == ST_PID));
  a_r12_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PID && byte_end && len_q == '0) |=> (st_q == ST_CSUM));
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(len_q) && $stable(rx_q)));
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |=> !busy);

endmodule

// File: rtl/lin_flags.sv
module lin_flags
  import lin_pkg::*;
#(
  parameter int NUM = NUM_FLAGS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] set,
  input  logic           wr_en,
  input  logic [NUM-1:0] wr_data,
  input  logic [NUM-1:0] irq_en,
  output logic [NUM-1:0] flags,
  output logic           irq
);

  logic [NUM-1:0] flags_q, clr;

  assign clr = wr_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | set;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & irq_en);

  for (genvar i = 0; i < NUM; i++) begin : g_flag_chk
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags_q[i]);
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[i] && !set[i]) |=> !flags_q[i]);
  end

  a_r9_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

endmodule

// File: rtl/lin_frame_master.sv
module lin_frame_master
  import lin_pkg::*;
#(
  parameter  int MAX_LEN = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [7:0]           req_id,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_rx,
  input  logic                 req_brk13,
  input  logic                 req_autopar,
  input  logic                 req_enh,
  input  logic                 req_ckchk,
  input  logic                 wr_valid,
  input  logic [7:0]           wr_data,
  output logic                 wr_ready,
  input  logic                 rd_pop,
  output logic                 rd_avail,
  output logic [7:0]           rd_data,
  input  logic                 tx_ready,
  input  logic                 tx_done,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_break,
  output logic                 tx_brk_long,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 st_wr_en,
  input  logic [NUM_FLAGS-1:0] st_wr_data,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] status,
  output logic                 busy,
  output logic                 irq
);

  lin_state_e state;
  logic       ev_start, ev_tx_data, ev_rx_data, ev_rx_csum, ev_frame_done, rx_phase;
  logic       hold_full_q, rd_full_q, brk13_q, ckchk_q;
  logic [7:0] hold_q, rd_q, pid_q, pid_req, csum_tx, csum_add_byte;
  logic       ev_ovf, ev_ckerr;
  logic [NUM_FLAGS-1:0] flag_set;

  assign pid_req = req_autopar ? lin_protect(req_id[5:0]) : req_id;

  lin_seq #(.MAX_LEN(MAX_LEN)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_len(req_len), .req_rx(req_rx),
    .tx_ready(tx_ready), .tx_done(tx_done), .hold_full(hold_full_q),
    .rx_valid(rx_valid),
    .state(state), .busy(busy), .tx_valid(tx_valid),
    .ev_start(ev_start), .ev_tx_data(ev_tx_data), .ev_rx_data(ev_rx_data),
    .ev_rx_csum(ev_rx_csum), .ev_frame_done(ev_frame_done), .rx_phase(rx_phase)
  );

  assign csum_add_byte = ev_rx_data ? rx_data : hold_q;

  lin_csum i_csum (
    .clk(clk), .rst_n(rst_n),
    .init(ev_start), .init_val(req_enh ? pid_req : 8'h00),
    .add(ev_tx_data || ev_rx_data), .add_byte(csum_add_byte),
    .csum_out(csum_tx)
  );

  // frame attributes held for the header and the checksum compare
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q   <= 8'h00;
      brk13_q <= 1'b0;
      ckchk_q <= 1'b0;
    end else if (ev_start) begin
      pid_q   <= pid_req;
      brk13_q <= req_brk13;
      ckchk_q <= req_ckchk;
    end
  end

  // one-byte transmit holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= 8'h00;
    end else if (ev_tx_data) begin
      hold_full_q <= 1'b0;
    end else if (wr_valid && !hold_full_q) begin
      hold_full_q <= 1'b1;
      hold_q      <= wr_data;
    end
  end
  assign wr_ready = !hold_full_q;

  // receive read register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_full_q <= 1'b0;
      rd_q      <= 8'h00;
    end else if (ev_rx_data) begin
      rd_full_q <= 1'b1;
      rd_q      <= rx_data;
    end else if (rd_pop) begin
      rd_full_q <= 1'b0;
    end
  end
  assign rd_avail = rd_full_q;
  assign rd_data  = rd_q;

  always_comb begin
    case (state)
      ST_SYNC: tx_data = SYNC_BYTE;
      ST_PID:  tx_data = pid_q;
      ST_DATA: tx_data = hold_q;
      ST_CSUM: tx_data = csum_tx;
      default: tx_data = 8'h00;
    endcase
  end
  assign tx_break    = (state == ST_BRK);
  assign tx_brk_long = tx_break && brk13_q;

  assign ev_ovf   = ev_rx_data && rd_full_q && !rd_pop;
  assign ev_ckerr = ev_rx_csum && ckchk_q && (rx_data != csum_tx);

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_DONE]  = ev_frame_done;
    flag_set[FLAG_CKERR] = ev_ckerr;
    flag_set[FLAG_OVF]   = ev_ovf;
  end

  lin_flags #(.NUM(NUM_FLAGS)) i_flags (
    .clk(clk), .rst_n(rst_n),
    .set(flag_set), .wr_en(st_wr_en), .wr_data(st_wr_data),
    .irq_en(irq_en), .flags(status), .irq(irq)
  );

  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_data && rd_avail && !rd_pop) |=> status[FLAG_OVF]);
  a_r11_rx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_phase) |=> $stable(rd_data));
  a_r5_no_check: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_csum && !ckchk_q && !st_wr_en) |=> $stable(status[FLAG_CKERR]));
  a_r2_break_only_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    tx_brk_long |-> tx_break);

endmodule

// File: tb/test_lin_frame_master.sv
module test_lin_frame_master;

  localparam int NV = 7;
  // id, len, rx, brk13, enh, autopar, ckchk, bad_csum, data (byte 0 on top)
  localparam logic [81:0] VEC [NV] = '{
    {8'h3C, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0102_0000_0000_0000},
    {8'h10, 4'd8, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_8080_0102},
    {8'hAA, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0},
    {8'h05, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 64'h1234_5600_0000_0000},
    {8'h21, 4'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'hC300_0000_0000_0000},
    {8'h3F, 4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'hDEAD_BEEF_0000_0000},
    {8'h12, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_rx = 0, req_brk13 = 0, req_autopar = 0, req_enh = 0, req_ckchk = 0;
  logic [7:0] req_id = 0;
  logic [3:0] req_len = 0;
  logic wr_valid = 0, rd_pop = 0, tx_ready = 1, tx_done = 0, rx_valid = 0, st_wr_en = 0;
  logic [7:0] wr_data = 0, rx_data = 0;
  logic [2:0] st_wr_data = 0, irq_en = 0;
  logic wr_ready, rd_avail, tx_valid, tx_break, tx_brk_long, busy, irq;
  logic [7:0] rd_data, tx_data;
  logic [2:0] status;

  int checks = 0, errors = 0;
  int log_n = 0, done_cnt = 0, pend = 0;
  logic [7:0] log_b [0:15];
  logic       log_brk [0:15];
  logic       log_long [0:15];

  always #5 clk = ~clk;

  lin_frame_master i_lin_frame_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_len(req_len), .req_rx(req_rx),
    .req_brk13(req_brk13), .req_autopar(req_autopar), .req_enh(req_enh), .req_ckchk(req_ckchk),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_pop(rd_pop), .rd_avail(rd_avail), .rd_data(rd_data),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_break(tx_break), .tx_brk_long(tx_brk_long),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .irq_en(irq_en),
    .status(status), .busy(busy), .irq(irq)
  );

  // UART model: log each offered item, report done three cycles later
  always @(negedge clk) begin
    tx_done = 1'b0;
    if (tx_valid) begin
      if (log_n < 16) begin
        log_b[log_n] = tx_data; log_brk[log_n] = tx_break; log_long[log_n] = tx_brk_long;
      end
      log_n++;
      pend = 3;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin tx_done = 1'b1; done_cnt++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pid(input logic [7:0] id, input logic apar);
    logic [7:0] r;
    r = id;
    if (apar) begin
      r[6] = ^(id[5:0] & 6'b010111);
      r[7] = ~^(id[5:0] & 6'b111010);
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_csum(input logic enh, input logic [7:0] pid,
                                          input logic [63:0] d, input int n);
    int s;
    s = enh ? int'(pid) : 0;
    for (int k = 0; k < n; k++) s += int'(d[63-8*k -: 8]);
    while (s > 255) s = (s & 255) + (s >> 8);
    return ~s[7:0];
  endfunction

  task automatic start_frame(input logic [7:0] id, input int len, input logic rx, input logic b13,
                             input logic enh, input logic apar, input logic ck);
    @(negedge clk);
    log_n = 0; done_cnt = 0;
    req_id = id; req_len = 4'(len); req_rx = rx; req_brk13 = b13;
    req_enh = enh; req_autopar = apar; req_ckchk = ck; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    wr_data = b;
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_header();
    while (done_cnt < 3) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic clear_all();
    st_wr_data = 3'b111; st_wr_en = 1'b1;
    @(negedge clk);
    st_wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R6, R9)
    chk(status == 3'b000, "R6 reset status", status, 0);
    chk(!busy && !tx_valid, "R6 reset busy/tx_valid", {busy, tx_valid}, 0);
    chk(wr_ready && !rd_avail && !irq, "R9 reset ready/avail/irq", {wr_ready, rd_avail, irq}, 3'b100);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] id, pid, cs;
      logic [63:0] d;
      int len;
      logic rx, b13, enh, apar, ck, bad;
      id = VEC[v][81:74]; len = int'(VEC[v][73:70]); rx = VEC[v][69]; b13 = VEC[v][68];
      enh = VEC[v][67]; apar = VEC[v][66]; ck = VEC[v][65]; bad = VEC[v][64]; d = VEC[v][63:0];
      pid = exp_pid(id, apar);
      cs = exp_csum(enh, pid, d, len);
      start_frame(id, len, rx, b13, enh, apar, ck);
      if (!rx) begin
        for (int k = 0; k < len; k++) push(d[63-8*k -: 8]);
      end else begin
        wait_header();
        for (int k = 0; k < len; k++) begin
          send_rx(d[63-8*k -: 8]);
          chk(rd_avail && rd_data == d[63-8*k -: 8], "R5 rx data byte", rd_data, d[63-8*k -: 8]);
          pop();
        end
        send_rx(bad ? (cs ^ 8'h01) : cs);
      end
      wait_idle();
      chk(log_n == (rx ? 3 : 4 + len), "R1 item count", log_n, rx ? 3 : 4 + len);
      chk(log_brk[0] && log_long[0] == b13, "R2 break item", {log_brk[0], log_long[0]}, {1'b1, b13});
      chk(!log_brk[1] && log_b[1] == 8'h55, "R1 sync byte", log_b[1], 8'h55);
      chk(log_b[2] == pid, "R3 identifier byte", log_b[2], pid);
      if (!rx) begin
        for (int k = 0; k < len; k++)
          chk(log_b[3+k] == d[63-8*k -: 8], "R1 tx data byte", log_b[3+k], d[63-8*k -: 8]);
        chk(log_b[3+len] == cs, len == 0 ? "R12 R4 checksum empty frame" : "R4 tx checksum",
            log_b[3+len], cs);
      end
      chk(status[0], len == 0 ? "R12 R6 frame done" : "R6 frame done", status, 3'b001);
      chk(status[1] == (rx && ck && bad), "R5 checksum error flag", status[1], rx && ck && bad);
      chk(!status[2], "R7 no overflow", status[2], 0);
      clear_all();
      chk(status == 3'b000, "R8 write-1-to-clear", status, 0);
    end

    // overflow: two bytes without a pop (R7)
    start_frame(8'h01, 2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_header();
    send_rx(8'h11);
    send_rx(8'h22);
    chk(status[2], "R7 overflow flag", status, 3'b100);
    chk(rd_avail && rd_data == 8'h22, "R7 newest byte kept", rd_data, 8'h22);
    send_rx(8'h00);
    wait_idle();
    pop();
    clear_all();

    // set and clear in the same cycle (R8), interrupt masking (R9)
    start_frame(8'h07, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_header();
    st_wr_data = 3'b001; st_wr_en = 1'b1;
    send_rx(8'h5A);
    st_wr_en = 1'b0;
    chk(status[0], "R8 set wins over clear", status, 3'b001);
    irq_en = 3'b001;
    @(negedge clk);
    chk(irq, "R9 enabled flag raises irq", irq, 1);
    irq_en = 3'b110;
    @(negedge clk);
    chk(!irq, "R9 masked flag keeps irq low", irq, 0);
    irq_en = 3'b000;
    clear_all();

    // request while busy (R10)
    start_frame(8'h3C, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    req_id = 8'h15; req_rx = 1'b1; req_len = 4'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    push(8'h77);
    wait_idle();
    chk(log_b[2] == exp_pid(8'h3C, 1'b1), "R10 running frame keeps its id", log_b[2], exp_pid(8'h3C, 1'b1));
    repeat (10) @(negedge clk);
    chk(!busy && log_n == 5, "R10 no second frame", log_n, 5);
    clear_all();

    // receive byte while idle (R11)
    send_rx(8'hA5);
    chk(!rd_avail && status == 3'b000, "R11 idle rx ignored", {rd_avail, status}, 0);

    // length above the limit is cut to MAX_LEN (R12)
    start_frame(8'h02, 12, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) push(8'(k + 1));
    wait_idle();
    chk(log_n == 12, "R12 length limited", log_n, 12);
    clear_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule